// File: doc/BRIEF.md
# DDR2 Per-Bank Row Timing Checker

This block watches the command stream a memory controller sends to an eight-bank DDR2 device. It reports whether each command keeps to the row timings of the bank it targets. Each bank has its own small record: whether a row is open, whether an internal auto-precharge is still waiting, and saturating counters of the clock cycles since the bank's last activate and since its last precharge. The checker has no say over the traffic. It gives a verdict for every sampled command and keeps sticky violation flags, together with the first offending command for later debug.

Commands arrive as a pre-decoded operation code, a bank number and the auto-precharge flag, which a controller takes from column-address bit 10. The command input is qualified by `cmd_valid` only. A passive observer can never stall the bus, so there is no ready signal and no back-pressure, and every valid beat is judged. Each limit is a parameter in whole clock cycles: tRCD, tRP, tRAS and tRC. The defaults of 4, 4, 12 and 16 fit a 266 MHz clock.

In this brief the *distance* between two events is the difference between the indices of the rising clock edges at which they happen. An activate at edge 10 and a read at edge 14 are 4 apart.

Top module: `ddr2_bank_timing_chk`

## Requirements
- R1: The verdict for the command sampled at a rising edge appears on `chk_vld`/`chk_ok` after that same edge. `chk_vld` repeats `cmd_valid`. An invalid beat, a NOP (op 0) or an unused code (op 7) is legal and changes no bank state.
- R2: An activate (op 1) raises the protocol code (bit 4) if its bank already has an open row. It raises the RP code (bit 1) if the distance from that bank's last precharge is below T_RP. It raises the RC code (bit 3) if the distance from that bank's previous activate is below T_RC. The activate opens the row in every case.
- R3: A read (op 2) or write (op 3) to a bank with no open row raises the protocol code (bit 4). Otherwise it raises the RCD code (bit 0) when the distance from the bank's activate is below T_RCD.
- R4: A precharge (op 4) to an open bank raises the RAS code (bit 2) when the distance from its activate is below T_RAS, and closes the row. A precharge to an idle bank is legal and has no effect.
- R5: Banks are independent. A command never changes the timing state of a bank it does not address. Precharge-all is the only exception.
- R6: A read or write with `cmd_ap`=1 to an open bank closes it. Its internal precharge happens at the later of the command's edge and the edge at distance T_RAS from the activate, and tRP counts from there. An activate made before that point raises RP and cancels the pending precharge, which is then taken to occur at that activate.
- R7: Precharge-all (op 5) closes every open bank. It raises RAS if any open bank is under T_RAS, and the reported bank is the lowest-numbered such bank.
- R8: Refresh (op 6) is legal only when every bank is idle, has no pending auto-precharge and is at least T_RP past its precharge. Otherwise it raises the refresh code (bit 5) and reports the lowest-numbered bank that is not ready.
- R9: `viol_sticky` collects every code raised and drops a bit only when `viol_clr` is high. A violation in the same cycle as a clear is kept.
- R10: The first violation after reset or clear latches `first_vld`, `first_bank`, `first_op` and `first_code`. These hold until the next clear.
- R11: After reset all banks are idle and count as long past every limit, and every output is 0 except `chk_ok`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_op | input | 3 | 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA, 6 REF |
| cmd_bank | input | 3 | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for RD/WR |
| viol_clr | input | 1 | Clears sticky codes and first-violation record |
| chk_vld | output | 1 | Verdict present for previous edge's command |
| chk_ok | output | 1 | Previous command met all rules |
| viol_sticky | output | 6 | Accumulated codes: 0 RCD, 1 RP, 2 RAS, 3 RC, 4 protocol, 5 refresh |
| first_vld | output | 1 | First-violation record holds data |
| first_bank | output | 3 | Bank of first violation |
| first_op | output | 3 | Operation of first violation |
| first_code | output | 6 | Codes of first violation |

## Verification
All results are registered at the same rising edge that samples the command, so the verdict, the sticky codes and the first-violation record for a command are all due one cycle later. The counters take their new values at that edge too, so a command issued d edges after an activate sees a distance of exactly d. The bench drives each command on a falling edge and runs a distance-based reference model of every bank at that moment. At the next falling edge it compares all outputs, before it drives the following command. This keeps each check aligned to exactly one command.

// File: rtl/ddr2_tchk_pkg.sv
package ddr2_tchk_pkg;

  typedef logic [2:0] op_t;

  localparam op_t OP_NOP  = 3'd0;
  localparam op_t OP_ACT  = 3'd1;
  localparam op_t OP_RD   = 3'd2;
  localparam op_t OP_WR   = 3'd3;
  localparam op_t OP_PRE  = 3'd4;
  localparam op_t OP_PREA = 3'd5;
  localparam op_t OP_REF  = 3'd6;

  localparam int VCODES  = 6;
  localparam int V_RCD   = 0;
  localparam int V_RP    = 1;
  localparam int V_RAS   = 2;
  localparam int V_RC    = 3;
  localparam int V_PROTO = 4;
  localparam int V_REF   = 5;

  typedef logic [VCODES-1:0] vcode_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
  import ddr2_tchk_pkg::*;
#(
  parameter int TRCD = 4,
  parameter int TRP  = 4,
  parameter int TRAS = 12,
  parameter int TRC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic col_i,
  input  logic ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic rcd_ok_o,
  output logic ras_ok_o,
  output logic rc_ok_o,
  output logic rp_ok_o
);

  localparam int ACAP = max3(TRCD, TRAS, TRC);
  localparam int AW   = $clog2(ACAP + 1);
  localparam int PW   = $clog2(TRP + 1);
  localparam logic [AW-1:0] K_ACAP = AW'(ACAP);
  localparam logic [AW-1:0] K_RCD  = AW'(TRCD);
  localparam logic [AW-1:0] K_RAS  = AW'(TRAS);
  localparam logic [AW-1:0] K_RC   = AW'(TRC);
  localparam logic [PW-1:0] K_RP   = PW'(TRP);

  logic [AW-1:0] act_cnt, act_inc;
  logic [PW-1:0] pre_cnt, pre_inc;
  logic          open_q, pend_q;

  assign act_inc = (act_cnt == K_ACAP) ? act_cnt : act_cnt + 1'b1;
  assign pre_inc = (pre_cnt == K_RP)   ? pre_cnt : pre_cnt + 1'b1;

  assign ras_ok_o = (act_cnt >= K_RAS);
  assign rcd_ok_o = (act_cnt >= K_RCD);
  assign rc_ok_o  = (act_cnt >= K_RC);
  assign rp_ok_o  = (pre_cnt >= K_RP) && !pend_q;
  assign open_o   = open_q;

  // Counters hold the distance in edges since the last activate / precharge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt <= K_ACAP;
      pre_cnt <= K_RP;
      open_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      act_cnt <= act_inc;
      pre_cnt <= pre_inc;
      if (act_i) begin
        open_q  <= 1'b1;
        pend_q  <= 1'b0;
        act_cnt <= AW'(1);
      end else if (col_i && ap_i && open_q) begin
        open_q <= 1'b0;
        if (ras_ok_o) begin
          pre_cnt <= PW'(1);
        end else begin
          pend_q  <= 1'b1;
          pre_cnt <= '0;
        end
      end else if (pre_i && open_q) begin
        open_q  <= 1'b0;
        pre_cnt <= PW'(1);
      end else if (pend_q) begin
        if (ras_ok_o) begin
          pend_q  <= 1'b0;
          pre_cnt <= PW'(1);
        end else begin
          pre_cnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/ddr2_cmd_judge.sv
module ddr2_cmd_judge
  import ddr2_tchk_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             valid_i,
  input  op_t              op_i,
  input  logic [BW-1:0]    bank_i,
  input  logic [NBANK-1:0] open_v,
  input  logic [NBANK-1:0] rcd_ok_v,
  input  logic [NBANK-1:0] ras_ok_v,
  input  logic [NBANK-1:0] rc_ok_v,
  input  logic [NBANK-1:0] rp_ok_v,
  output vcode_t           code_o,
  output logic [BW-1:0]    culprit_o
);

  logic [NBANK-1:0] ras_bad, ref_bad;
  logic [BW-1:0]    ras_low, ref_low;

  assign ras_bad = open_v & ~ras_ok_v;
  assign ref_bad = open_v | ~rp_ok_v;

  always_comb begin
    ras_low = '0;
    ref_low = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (ras_bad[i]) ras_low = BW'(i);
      if (ref_bad[i]) ref_low = BW'(i);
    end
  end

  always_comb begin
    code_o    = '0;
    culprit_o = bank_i;
    if (valid_i) begin
      case (op_i)
        OP_ACT: begin
          code_o[V_PROTO] = open_v[bank_i];
          code_o[V_RP]    = !rp_ok_v[bank_i];
          code_o[V_RC]    = !rc_ok_v[bank_i];
        end
        OP_RD, OP_WR: begin
          if (!open_v[bank_i]) code_o[V_PROTO] = 1'b1;
          else                 code_o[V_RCD]   = !rcd_ok_v[bank_i];
        end
        OP_PRE: begin
          code_o[V_RAS] = open_v[bank_i] && !ras_ok_v[bank_i];
        end
        OP_PREA: begin
          code_o[V_RAS] = |ras_bad;
          culprit_o     = ras_low;
        end
        OP_REF: begin
          code_o[V_REF] = |ref_bad;
          culprit_o     = ref_low;
        end
        default: code_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_viol_log.sv
module ddr2_viol_log
  import ddr2_tchk_pkg::*;
#(
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  op_t           op_i,
  input  vcode_t        code_i,
  input  logic [BW-1:0] culprit_i,
  input  logic          clr_i,
  output logic          chk_vld,
  output logic          chk_ok,
  output vcode_t        viol_sticky,
  output logic          first_vld,
  output logic [BW-1:0] first_bank,
  output op_t           first_op,
  output vcode_t        first_code
);

  logic bad;
  logic keep_first;

  assign bad        = |code_i;
  assign keep_first = first_vld && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld     <= 1'b0;
      chk_ok      <= 1'b1;
      viol_sticky <= '0;
      first_vld   <= 1'b0;
      first_bank  <= '0;
      first_op    <= OP_NOP;
      first_code  <= '0;
    end else begin
      chk_vld     <= valid_i;
      chk_ok      <= !bad;
      viol_sticky <= (clr_i ? '0 : viol_sticky) | code_i;
      if (!keep_first) begin
        first_vld <= bad;
        if (bad) begin
          first_bank <= culprit_i;
          first_op   <= op_i;
          first_code <= code_i;
        end else if (clr_i) begin
          first_bank <= '0;
          first_op   <= OP_NOP;
          first_code <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/ddr2_bank_timing_chk.sv
module ddr2_bank_timing_chk
  import ddr2_tchk_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int T_RCD = 4,
  parameter int T_RP  = 4,
  parameter int T_RAS = 12,
  parameter int T_RC  = 16,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  input  logic          cmd_ap,
  input  logic          viol_clr,
  output logic          chk_vld,
  output logic          chk_ok,
  output logic [5:0]    viol_sticky,
  output logic          first_vld,
  output logic [BW-1:0] first_bank,
  output logic [2:0]    first_op,
  output logic [5:0]    first_code
);

  logic [NBANK-1:0] bank_open, rcd_ok, ras_ok, rc_ok, rp_ok;
  vcode_t           code;
  logic [BW-1:0]    culprit;
  logic             is_col, is_all_pre;

  assign is_col     = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  assign is_all_pre = cmd_valid && (cmd_op == OP_PREA);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = cmd_valid && (cmd_bank == BW'(g));
    ddr2_bank_track #(
      .TRCD(T_RCD), .TRP(T_RP), .TRAS(T_RAS), .TRC(T_RC)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (hit && (cmd_op == OP_ACT)),
      .col_i    (hit && is_col),
      .ap_i     (cmd_ap),
      .pre_i    ((hit && (cmd_op == OP_PRE)) || is_all_pre),
      .open_o   (bank_open[g]),
      .rcd_ok_o (rcd_ok[g]),
      .ras_ok_o (ras_ok[g]),
      .rc_ok_o  (rc_ok[g]),
      .rp_ok_o  (rp_ok[g])
    );
  end

  ddr2_cmd_judge #(.NBANK(NBANK)) u_judge (
    .valid_i   (cmd_valid),
    .op_i      (cmd_op),
    .bank_i    (cmd_bank),
    .open_v    (bank_open),
    .rcd_ok_v  (rcd_ok),
    .ras_ok_v  (ras_ok),
    .rc_ok_v   (rc_ok),
    .rp_ok_v   (rp_ok),
    .code_o    (code),
    .culprit_o (culprit)
  );

  ddr2_viol_log #(.BW(BW)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (cmd_valid),
    .op_i        (cmd_op),
    .code_i      (code),
    .culprit_i   (culprit),
    .clr_i       (viol_clr),
    .chk_vld     (chk_vld),
    .chk_ok      (chk_ok),
    .viol_sticky (viol_sticky),
    .first_vld   (first_vld),
    .first_bank  (first_bank),
    .first_op    (first_op),
    .first_code  (first_code)
  );

endmodule

// File: rtl/ddr2_tchk_checker.sv
module ddr2_tchk_checker
  import ddr2_tchk_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [BW-1:0]    cmd_bank,
  input logic             viol_clr,
  input logic [NBANK-1:0] bank_open,
  input logic             chk_vld,
  input logic             chk_ok,
  input logic [5:0]       viol_sticky,
  input logic             first_vld,
  input logic [BW-1:0]    first_bank,
  input logic [5:0]       first_code
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> chk_vld);

  assert_idle_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!chk_vld && chk_ok));

  assert_act_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT && bank_open[cmd_bank])
      |=> (!chk_ok && viol_sticky[V_PROTO]));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT) |=> bank_open[$past(cmd_bank)]);

  assert_col_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank])
      |=> viol_sticky[V_PROTO]);

  assert_prea_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PREA) |=> (bank_open == '0));

  assert_ref_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_REF && (|bank_open)) |=> (!chk_ok && viol_sticky[V_REF]));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_clr |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

  assert_bad_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && !chk_ok) |-> (viol_sticky != '0 && first_vld));

  assert_first_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (first_vld && !viol_clr) |=> (first_vld && $stable(first_bank) && $stable(first_code)));

endmodule

bind ddr2_bank_timing_chk ddr2_tchk_checker #(.NBANK(NBANK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .viol_clr    (viol_clr),
  .bank_open   (bank_open),
  .chk_vld     (chk_vld),
  .chk_ok      (chk_ok),
  .viol_sticky (viol_sticky),
  .first_vld   (first_vld),
  .first_bank  (first_bank),
  .first_code  (first_code)
);

// File: tb/ddr2_bank_timing_chk_test.sv
module ddr2_bank_timing_chk_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int TRCD = 4;
  localparam int TRP  = 4;
  localparam int TRAS = 12;
  localparam int TRC  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       cmd_ap = 1'b0;
  logic       viol_clr = 1'b0;
  logic       chk_vld, chk_ok, first_vld;
  logic [5:0] viol_sticky, first_code;
  logic [2:0] first_bank, first_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_bank_timing_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .viol_clr(viol_clr),
    .chk_vld(chk_vld), .chk_ok(chk_ok), .viol_sticky(viol_sticky),
    .first_vld(first_vld), .first_bank(first_bank), .first_op(first_op),
    .first_code(first_code)
  );

  int n_checks = 0;
  int n_fail = 0;

  // Reference model: edge indices of events, per bank.
  int  now = 0;
  int  last_act [NB];
  int  pre_edge [NB];
  bit  m_open [NB];
  logic [5:0] e_sticky = '0;
  logic       e_fvld = 1'b0;
  logic [2:0] e_fbank = '0, e_fop = '0;
  logic [5:0] e_fcode = '0;

  function automatic logic [5:0] mcode(input logic [2:0] op, input int b, output int cul);
    logic [5:0] c;
    c = '0;
    cul = b;
    case (op)
      3'd1: begin
        if (m_open[b]) c[4] = 1'b1;
        if (now - pre_edge[b] < TRP) c[1] = 1'b1;
        if (now - last_act[b] < TRC) c[3] = 1'b1;
      end
      3'd2, 3'd3: begin
        if (!m_open[b]) c[4] = 1'b1;
        else if (now - last_act[b] < TRCD) c[0] = 1'b1;
      end
      3'd4: if (m_open[b] && now - last_act[b] < TRAS) c[2] = 1'b1;
      3'd5: for (int i = NB - 1; i >= 0; i--)
              if (m_open[i] && now - last_act[i] < TRAS) begin c[2] = 1'b1; cul = i; end
      3'd6: for (int i = NB - 1; i >= 0; i--)
              if (m_open[i] || now - pre_edge[i] < TRP) begin c[5] = 1'b1; cul = i; end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic void mapply(input logic [2:0] op, input int b, input bit ap);
    case (op)
      3'd1: begin
        m_open[b] = 1'b1;
        if (pre_edge[b] > now) pre_edge[b] = now;
        last_act[b] = now;
      end
      3'd2, 3'd3: if (m_open[b] && ap) begin
        m_open[b] = 1'b0;
        pre_edge[b] = (now > last_act[b] + TRAS) ? now : last_act[b] + TRAS;
      end
      3'd4: if (m_open[b]) begin m_open[b] = 1'b0; pre_edge[b] = now; end
      3'd5: for (int i = 0; i < NB; i++)
              if (m_open[i]) begin m_open[i] = 1'b0; pre_edge[i] = now; end
      default: ;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, now);
    end
  endtask

  // One cycle: drive at falling edge, compare one cycle later.
  task automatic cyc(input bit v, input logic [2:0] op, input int b, input bit ap,
                     input bit clr, input string tag);
    logic [5:0] c;
    int cul;
    cmd_valid = v; cmd_op = op; cmd_bank = 3'(b); cmd_ap = ap; viol_clr = clr;
    c = v ? mcode(op, b, cul) : 6'd0;
    if (!v) cul = 0;
    e_sticky = (clr ? 6'd0 : e_sticky) | c;
    if (clr) begin e_fvld = 1'b0; e_fbank = '0; e_fop = '0; e_fcode = '0; end
    if (!e_fvld && c != 0) begin
      e_fvld = 1'b1; e_fbank = 3'(cul); e_fop = op; e_fcode = c;
    end
    if (v) mapply(op, b, ap);
    @(negedge clk);
    now++;
    check(chk_vld === v, tag, "chk_vld", 32'(chk_vld), 32'(v));
    check(chk_ok === (c == 0), tag, "chk_ok", 32'(chk_ok), 32'(c == 0));
    check(viol_sticky === e_sticky, tag, "sticky", 32'(viol_sticky), 32'(e_sticky));
    check(first_vld === e_fvld && (!e_fvld ||
          (first_bank === e_fbank && first_op === e_fop && first_code === e_fcode)),
          tag, "first{vld,bank,op,code}",
          {first_vld, first_bank, first_op, first_code},
          {e_fvld, e_fbank, e_fop, e_fcode});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      last_act[i] = -1000; pre_edge[i] = -1000; m_open[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(chk_vld === 1'b0 && chk_ok === 1'b1 && viol_sticky === 6'd0 &&
          first_vld === 1'b0 && first_bank === 3'd0 && first_op === 3'd0 &&
          first_code === 6'd0, "R11", "reset outputs",
          {chk_vld, chk_ok, viol_sticky, first_vld}, {1'b0, 1'b1, 6'd0, 1'b0});
    rst_n = 1'b1;

    // R1: idle, NOP and unused code
    idle(2, "R1");
    cyc(1, 3'd0, 2, 0, 0, "R1");
    cyc(1, 3'd7, 5, 1, 0, "R1");
    // R11: first refresh after reset is legal
    cyc(1, 3'd6, 0, 0, 0, "R11");

    // R3: read too early, then on time; read to closed bank
    cyc(1, 3'd1, 0, 0, 0, "R2");
    cyc(1, 3'd2, 0, 0, 0, "R3");
    idle(2, "R3");
    cyc(1, 3'd3, 0, 0, 0, "R3");
    cyc(1, 3'd2, 6, 0, 0, "R3");
    // R5: other banks independent
    cyc(1, 3'd1, 1, 0, 0, "R5");
    cyc(1, 3'd1, 2, 0, 0, "R5");
    // R2: activate on open bank (protocol + RC)
    cyc(1, 3'd1, 0, 0, 0, "R2");
    // R9: clear together with a new violation keeps it
    cyc(1, 3'd2, 7, 0, 1, "R9");
    cyc(1, 3'd0, 0, 0, 1, "R9");
    // R4: early precharge, precharge to idle bank
    cyc(1, 3'd4, 1, 0, 0, "R4");
    cyc(1, 3'd4, 4, 0, 0, "R4");
    // R2: activate too soon after precharge
    cyc(1, 3'd1, 1, 0, 0, "R2");
    // R10: first record held through later violations
    cyc(1, 3'd2, 5, 0, 0, "R10");
    // R8: refresh while banks open
    cyc(1, 3'd6, 0, 0, 0, "R8");
    // R7: precharge-all with young rows
    cyc(1, 3'd5, 0, 0, 1, "R7");
    idle(TRP - 2, "R8");
    cyc(1, 3'd6, 0, 0, 0, "R8");
    cyc(1, 3'd6, 0, 0, 0, "R8");
    idle(20, "R2");
    cyc(1, 3'd0, 0, 0, 1, "R9");

    // R6: auto-precharge before tRAS defers the internal precharge
    cyc(1, 3'd1, 3, 0, 0, "R6");
    idle(TRCD - 1, "R6");
    cyc(1, 3'd2, 3, 1, 0, "R6");
    cyc(1, 3'd6, 0, 0, 0, "R6");
    idle(TRAS - TRCD - 2, "R6");
    for (int k = 0; k < TRP + 2; k++) cyc(1, 3'd6, 0, 0, 1, "R6");
    idle(4, "R6");
    // R6: activate during pending precharge
    cyc(1, 3'd1, 4, 0, 1, "R6");
    idle(TRCD - 1, "R6");
    cyc(1, 3'd3, 4, 1, 0, "R6");
    cyc(1, 3'd1, 4, 0, 0, "R6");
    idle(30, "R6");
    // R6: auto-precharge after tRAS acts at once
    cyc(1, 3'd1, 5, 0, 1, "R6");
    idle(TRAS + 2, "R6");
    cyc(1, 3'd2, 5, 1, 0, "R6");
    idle(TRP - 1, "R6");
    cyc(1, 3'd1, 5, 0, 0, "R6");
    idle(20, "R6");
    // R7: lowest offending bank reported
    cyc(1, 3'd1, 6, 0, 1, "R7");
    cyc(1, 3'd1, 2, 0, 0, "R7");
    cyc(1, 3'd5, 0, 0, 1, "R7");

    // Random traffic
    void'($urandom(32'h1D2E_3F40));
    for (int n = 0; n < 5000; n++) begin
      int r, o;
      r = int'($urandom % 16);
      o = (r < 6) ? 0 : (r < 9) ? 1 : (r < 11) ? 2 : (r < 12) ? 3 :
          (r < 14) ? 4 : (r < 15) ? 5 : 6;
      cyc(($urandom % 8) != 0, 3'(o), int'($urandom % NB), ($urandom % 2) == 1,
          ($urandom % 64) == 0, "R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule